// File: doc/BRIEF.md
# Nonvolatile Write Protection Sequencer

This block sits between a host write port and the controller of an 8 KB nonvolatile array. It watches every host write for short command sequences aimed at two fixed offsets inside the array's address window, and uses them to drive two independent protection layers. The first is a global protect flag that is set out of reset. While it is set, a data write reaches the array only if a three-byte unlock sequence came just before it. The second is an 8-bit lock register with one bit per 1 KB block. A locked block refuses every write, whatever the global flag says.

Command bytes are consumed and are never forwarded to the array. The array window is relocatable: address bits [15:13] must equal `map_base`. Bit 12 selects the memory plane and plays no part in command matching. The programming timer lives outside this block. It reports through `window_expired` that the page-load window has closed. That event abandons any partial sequence and closes any open write or lock-register access.

Top module: `nvm_wr_guard`

## Requirements
- R1: After reset `prot_on` is 1, `wr_open` is 0, `bpr_q` equals the BPR_RESET parameter (default 8'h00), and with no write `mem_we` and `bpr_we` are 0.
- R2: While `prot_on` is 1 and `wr_open` is 0, `mem_we` stays 0 for every write.
- R3: The writes 8'hAA to offset 12'h555, then 8'h55 to offset 12'hAAA, then 8'hA0 to offset 12'h555 set `wr_open` on the next cycle. From then on, each data write is passed to the array (`mem_we`=1) until the window expires. None of the three command writes asserts `mem_we`.
- R4: A command byte matches only when wr_addr[15:13] equals `map_base`, wr_addr[11:0] equals the expected offset and the data equals the expected code. wr_addr[12] (the plane) is ignored for matching.
- R5: A cycle with `window_expired`=1 returns the sequencer to idle and clears `wr_open` and the open lock-register access before that cycle's write is judged. A write in the same cycle is therefore evaluated as if from idle, and is blocked while protected.
- R6: `mem_we` is never 1 for an address whose block, wr_addr[12:10], has its bit set in `bpr_q`.
- R7: The writes AA@555, 55@AAA, BPR_KEY (default 8'hC0)@555, AA@555, 55@AAA open the lock register. The next write inside the window pulses `bpr_we`, loads its data into `bpr_q` on the next cycle, and does not assert `mem_we`.
- R8: A cycle with `cfg_wr`=1 or `bpr_we`=1 makes `prot_on` 1 on the next cycle.
- R9: The writes AA@555, 55@AAA, 80@555, AA@555, 55@AAA, 20@555 clear `prot_on` on the next cycle and leave `bpr_q` unchanged. With `prot_on` at 0, data writes pass without an unlock, except those to locked blocks.
- R10: A write that does not match the next expected command byte returns the sequencer to idle. That write is then judged as an ordinary data write under the current protection.
- R11: A write with wr_addr[15:13] different from `map_base` never asserts `mem_we`.
- R12: If `cfg_wr` arrives in the same cycle as the last byte of the deactivation sequence, `prot_on` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 16 | Host write address |
| wr_data | input | 8 | Host write data |
| map_base | input | 3 | Window base compared with wr_addr[15:13] |
| cfg_wr | input | 1 | Pulse when a nonvolatile configuration register is written |
| window_expired | input | 1 | Page-load window has closed |
| mem_we | output | 1 | Write enable forwarded to the array controller |
| bpr_we | output | 1 | Strobe loading the block lock register |
| prot_on | output | 1 | Global protection flag |
| wr_open | output | 1 | Unlock sequence seen; page writes allowed |
| bpr_q | output | 8 | Block lock register, one bit per 1 KB block |

## Verification
The stimulus covers several kinds of write stream. Clean command sequences in both planes show that the plane bit does not matter. Sequences broken by a stray write or a wrong base show the fall back to ordinary-write handling. Sequences cut by window expiry, including expiry in the same cycle as a write, show that partial state is dropped first. Data writes under every mix of the global flag and the block locks separate the two protection layers. The deactivation run checks that the lock register survives it. The collision between `cfg_wr` and the last deactivation byte checks the priority of setting protection over clearing it.

// File: rtl/nvm_wr_guard.sv
`timescale 1ns/1ps
module nvm_wr_guard #(
  parameter logic [7:0] BPR_RESET = 8'h00,
  parameter logic [7:0] BPR_KEY   = 8'hC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  map_base,
  input  logic        cfg_wr,
  input  logic        window_expired,
  output logic        mem_we,
  output logic        bpr_we,
  output logic        prot_on,
  output logic        wr_open,
  output logic [7:0]  bpr_q
);
  localparam logic [11:0] OFF_A = 12'h555;
  localparam logic [11:0] OFF_B = 12'hAAA;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5, ST_B3, ST_B4
  } st_t;

  st_t  st_q, st_cur, st_nx;
  logic open_q, bopen_q, open_cur, bopen_cur;
  logic cmd, unlock_done, deact_done, bopen_done;

  assign st_cur    = window_expired ? ST_IDLE : st_q;
  assign open_cur  = open_q  & ~window_expired;
  assign bopen_cur = bopen_q & ~window_expired;

  wire in_base = (wr_addr[15:13] == map_base);
  wire at_a    = in_base && (wr_addr[11:0] == OFF_A);
  wire at_b    = in_base && (wr_addr[11:0] == OFF_B);
  wire k_aa    = at_a && (wr_data == 8'hAA);
  wire k_55    = at_b && (wr_data == 8'h55);
  wire k_a0    = at_a && (wr_data == 8'hA0);
  wire k_80    = at_a && (wr_data == 8'h80);
  wire k_20    = at_a && (wr_data == 8'h20);
  wire k_key   = at_a && (wr_data == BPR_KEY);

  assign bpr_we = wr_valid && bopen_cur && in_base;

  always_comb begin
    st_nx       = st_cur;
    cmd         = 1'b0;
    unlock_done = 1'b0;
    deact_done  = 1'b0;
    bopen_done  = 1'b0;
    if (wr_valid) begin
      st_nx = ST_IDLE;
      if (!bpr_we) begin
        case (st_cur)
          ST_IDLE: if (k_aa) begin cmd = 1'b1; st_nx = ST_K1; end
          ST_K1:   if (k_55) begin cmd = 1'b1; st_nx = ST_K2; end
          ST_K2: begin
            if (k_a0)       begin cmd = 1'b1; unlock_done = 1'b1; end
            else if (k_80)  begin cmd = 1'b1; st_nx = ST_D3; end
            else if (k_key) begin cmd = 1'b1; st_nx = ST_B3; end
          end
          ST_D3:   if (k_aa) begin cmd = 1'b1; st_nx = ST_D4; end
          ST_D4:   if (k_55) begin cmd = 1'b1; st_nx = ST_D5; end
          ST_D5:   if (k_20) begin cmd = 1'b1; deact_done = 1'b1; end
          ST_B3:   if (k_aa) begin cmd = 1'b1; st_nx = ST_B4; end
          ST_B4:   if (k_55) begin cmd = 1'b1; bopen_done = 1'b1; end
          default: st_nx = ST_IDLE;
        endcase
      end
    end
  end

  assign mem_we = wr_valid && in_base && !cmd && !bpr_we &&
                  !bpr_q[wr_addr[12:10]] && (!prot_on || open_cur);
  assign wr_open = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      open_q  <= 1'b0;
      bopen_q <= 1'b0;
      prot_on <= 1'b1;
      bpr_q   <= BPR_RESET;
    end else begin
      st_q    <= st_nx;
      open_q  <= open_cur | unlock_done;
      bopen_q <= (bopen_cur & ~bpr_we) | bopen_done;
      if (cfg_wr || bpr_we) prot_on <= 1'b1;
      else if (deact_done)  prot_on <= 1'b0;
      if (bpr_we) bpr_q <= wr_data;
    end
  end
endmodule

// File: rtl/nvm_wr_guard_chk.sv
`timescale 1ns/1ps
module nvm_wr_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [15:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic [2:0]  map_base,
  input logic        cfg_wr,
  input logic        window_expired,
  input logic        mem_we,
  input logic        bpr_we,
  input logic        prot_on,
  input logic        wr_open,
  input logic [7:0]  bpr_q
);
  a_r2_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    prot_on && !wr_open |-> !mem_we);
  a_r6_block_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !bpr_q[wr_addr[12:10]]);
  a_r11_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_valid && wr_addr[15:13] == map_base));
  a_r7_bpr_load: assert property (@(posedge clk) disable iff (!rst_n)
    bpr_we |=> bpr_q == $past(wr_data));
  a_r7_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    !(bpr_we && mem_we));
  a_r8_reprotect: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || bpr_we) |=> prot_on);
  a_r9_bpr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !bpr_we |=> $stable(bpr_q));
  a_r5_expiry_closes: assert property (@(posedge clk) disable iff (!rst_n)
    window_expired && !wr_valid |=> !wr_open);
endmodule

bind nvm_wr_guard nvm_wr_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .map_base(map_base), .cfg_wr(cfg_wr),
  .window_expired(window_expired), .mem_we(mem_we), .bpr_we(bpr_we),
  .prot_on(prot_on), .wr_open(wr_open), .bpr_q(bpr_q)
);

// File: tb/nvm_wr_guard_bench.sv
`timescale 1ns/1ps
module nvm_wr_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] map_base = 3'b101;
  logic cfg_wr = 1'b0;
  logic window_expired = 1'b0;
  logic mem_we, bpr_we, prot_on, wr_open;
  logic [7:0] bpr_q;

  always #5 clk = ~clk;

  nvm_wr_guard u_nvm_wr_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .map_base(map_base), .cfg_wr(cfg_wr),
    .window_expired(window_expired), .mem_we(mem_we), .bpr_we(bpr_we),
    .prot_on(prot_on), .wr_open(wr_open), .bpr_q(bpr_q)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit done_flag = 0;
  string cur_req = "R1";

  logic [19:0] hist[$];
  bit m_open = 0, m_bopen = 0, m_prot = 1;
  logic [7:0] m_bpr = 8'h00;

  function automatic int seq_len(input int w);
    return (w == 0) ? 3 : (w == 1) ? 6 : 5;
  endfunction

  function automatic logic [19:0] seq_at(input int w, input int i);
    logic [19:0] u[3] = '{ {8'hAA,12'h555}, {8'h55,12'hAAA}, {8'hA0,12'h555} };
    logic [19:0] d[6] = '{ {8'hAA,12'h555}, {8'h55,12'hAAA}, {8'h80,12'h555},
                           {8'hAA,12'h555}, {8'h55,12'hAAA}, {8'h20,12'h555} };
    logic [19:0] b[5] = '{ {8'hAA,12'h555}, {8'h55,12'hAAA}, {8'hC0,12'h555},
                           {8'hAA,12'h555}, {8'h55,12'hAAA} };
    if (w == 0) return u[i];
    if (w == 1) return d[i];
    return b[i];
  endfunction

  function automatic bit pref_ok(input int w, input logic [19:0] k);
    if (hist.size() >= seq_len(w)) return 0;
    for (int i = 0; i < hist.size(); i++)
      if (hist[i] != seq_at(w, i)) return 0;
    return seq_at(w, hist.size()) == k;
  endfunction

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [15:0] a, input logic [7:0] d,
                      input bit ex, input bit cf);
    logic [19:0] k;
    bit e_open, e_bopen, hit, ld, cmd, ex_mem;
    int done;
    wr_valid = v; wr_addr = a; wr_data = d; window_expired = ex; cfg_wr = cf;
    #2;
    k = {d, a[11:0]};
    e_open  = m_open && !ex;
    e_bopen = m_bopen && !ex;
    if (ex) hist.delete();
    hit = (a[15:13] == map_base);
    ld  = v && e_bopen && hit;
    cmd = 0; done = -1;
    if (v && !ld && hit)
      for (int w = 0; w < 3; w++)
        if (pref_ok(w, k)) begin
          cmd = 1;
          if (hist.size() + 1 == seq_len(w)) done = w;
        end
    ex_mem = v && hit && !cmd && !ld && !m_bpr[a[12:10]] && (!m_prot || e_open);
    chk("mem_we",  {7'd0, mem_we},  {7'd0, ex_mem});
    chk("bpr_we",  {7'd0, bpr_we},  {7'd0, ld});
    chk("prot_on", {7'd0, prot_on}, {7'd0, m_prot});
    chk("wr_open", {7'd0, wr_open}, {7'd0, m_open});
    chk("bpr_q",   bpr_q,           m_bpr);
    @(posedge clk);
    if (v) begin
      if (cmd && done < 0) hist.push_back(k);
      else hist.delete();
    end
    m_open  = e_open || (done == 0);
    m_bopen = (e_bopen && !ld) || (done == 2);
    if (ld) m_bpr = d;
    if (cf || ld) m_prot = 1;
    else if (done == 1) m_prot = 0;
    @(negedge clk);
    wr_valid = 0; window_expired = 0; cfg_wr = 0;
  endtask

  task automatic idle(); step(0, 16'h0, 8'h0, 0, 0); endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d); step(1, a, d, 0, 0); endtask
  task automatic expire(); step(0, 16'h0, 8'h0, 1, 0); endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; idle(); idle();
    cur_req = "R2"; wr(16'hA100, 8'h11); wr(16'hB200, 8'h22);
    cur_req = "R3"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'hA0);
    idle(); wr(16'hA010, 8'h31); wr(16'hA011, 8'h32); wr(16'hB012, 8'h33);
    cur_req = "R5"; expire(); wr(16'hA013, 8'h34);
    cur_req = "R4"; wr(16'hB555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hB555, 8'hA0);
    wr(16'hA020, 8'h41); expire();
    wr(16'h6555, 8'hAA); wr(16'h6AAA, 8'h55); wr(16'h6555, 8'hA0); wr(16'hA021, 8'h42);
    cur_req = "R5"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); expire();
    wr(16'hA555, 8'hA0); wr(16'hA022, 8'h43);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'hA0);
    step(1, 16'hA023, 8'h44, 1, 0);
    cur_req = "R10"; wr(16'hA555, 8'hAA); wr(16'hA300, 8'h51); wr(16'hAAAA, 8'h55);
    wr(16'hA555, 8'hA0); wr(16'hA301, 8'h52);
    cur_req = "R9"; expire();
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'h80);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'h20);
    idle(); wr(16'hA400, 8'h61); wr(16'hBC00, 8'h62);
    cur_req = "R10"; wr(16'hA555, 8'hAA); wr(16'hA555, 8'h63);
    cur_req = "R11"; wr(16'h2400, 8'h64); wr(16'hE000, 8'h65);
    cur_req = "R7"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'hC0);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'h1000, 8'h77);
    wr(16'hA000, 8'h05); idle();
    cur_req = "R9"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'h80);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'h20); idle();
    cur_req = "R6"; wr(16'hA000, 8'h71); wr(16'hA3FF, 8'h72); wr(16'hA400, 8'h73);
    wr(16'hA800, 8'h74); wr(16'hAC00, 8'h75); wr(16'hB000, 8'h76);
    cur_req = "R8"; step(0, 16'h0, 8'h0, 0, 1); idle(); wr(16'hA400, 8'h81);
    cur_req = "R12"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'h80);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); step(1, 16'hA555, 8'h20, 0, 1);
    idle(); wr(16'hA400, 8'h82);
    cur_req = "R7"; wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hA555, 8'hC0);
    wr(16'hA555, 8'hAA); wr(16'hAAAA, 8'h55); expire(); wr(16'hA000, 8'hFF); idle();
    finish_run();
  end
endmodule